// File: doc/BRIEF.md
# Floating-Point Compare and Flag Unit

This block compares two single-precision operands and turns the outcome into a three-bit condition code. Operand A, the stack top, is always the left-hand side, and operand B is the right-hand side. A one-cycle strobe launches a compare. One clock later the block shows the code, an invalid-operation indication and a pop count. An external register stack uses that pop count to discard zero, one or two entries.

Three mode inputs travel with each strobe:

- **Quiet mode** tolerates quiet NaNs. Such a compare reports unordered and raises nothing.
- **Zero mode** replaces B with +0.0, so the compare becomes a sign test of A.
- **Route select** sends the code either to the coprocessor condition bits or to a CPU-style flag triple that a conditional branch can read directly. The set that is not selected keeps its previous contents.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When `valid_i` is sampled high on a clock edge, `done_o` is high for the following cycle. Otherwise `done_o` is low. After reset, every output is zero.
- R2: For ordered operands, A is the left-hand side. The three-bit code is 000 when A > B, 001 when A < B and 100 when A == B. The bit order is {C3,C2,C0} on `cc_o` and {ZF,PF,CF} on `cpu_o`.
- R3: Ordering follows sign-magnitude rules:
  - A negative operand is less than a positive one.
  - Between two negatives, the larger magnitude is the lesser value.
  - Infinities order beyond every finite value.
- R4: +0 and -0 compare equal.
- R5: If either compared operand is a NaN (exponent all ones, fraction non-zero), the code is 111 (unordered).
- R6: A NaN is quiet when fraction bit 22 is set and signalling otherwise. `invalid_o` is raised in three cases:
  - in ordinary mode (`quiet_i` = 0), for any NaN;
  - in quiet mode, for a signalling NaN;
  - never in quiet mode for a quiet NaN alone.
- R7: With `zero_i` = 1, A is compared against +0.0. The value of `op_b_i` then affects neither the code nor `invalid_o`.
- R8: With `cpu_flags_i` = 1, the code is written to `cpu_o` and `cc_o` holds. With `cpu_flags_i` = 0, the code is written to `cc_o` and `cpu_o` holds. Neither set changes in a cycle without a strobe.
- R9: During `done_o`, `pop_o` equals the requested `pops_i`, with a request of 3 limited to 2.
- R10: While `done_o` is low, `invalid_o` and `pop_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Compare strobe |
| op_a_i | input | 32 | Left-hand operand (stack top) |
| op_b_i | input | 32 | Right-hand operand |
| quiet_i | input | 1 | 1: quiet NaNs report unordered without invalid |
| zero_i | input | 1 | 1: compare A against +0.0 and ignore B |
| cpu_flags_i | input | 1 | 1: route the code to the CPU flag triple |
| pops_i | input | 2 | Requested stack pops |
| done_o | output | 1 | Result valid this cycle |
| cc_o | output | 3 | Coprocessor condition bits {C3,C2,C0} |
| cpu_o | output | 3 | CPU flags {ZF,PF,CF} |
| invalid_o | output | 1 | Invalid-operation indication |
| pop_o | output | 2 | Pop count for the external stack |

## Verification
Several of the block's outputs can all be produced by one strobe:

- an invalid indication from an ordinary-mode NaN;
- the route to the CPU flags;
- a clamped pop request.

A single strobe carrying a quiet NaN in ordinary mode, `cpu_flags_i` set and `pops_i` = 3 provokes all three together. The bench then judges that `cpu_o` reads 111, `invalid_o` is high, `pop_o` is 2 and `cc_o` has held its previous value.

A second coincidence pairs zero mode with a NaN on B. The bench expects the sign result of A with no invalid, which shows that the ignored operand reaches neither path.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int POP_W = 2;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic              done;
        logic              inv;
        logic [POP_W-1:0]  pops;
        logic [CODE_W-1:0] cc;
        logic [CODE_W-1:0] cpu;
    } fcmp_state_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              sign_o,
    output logic              zero_o,
    output logic              nan_o,
    output logic              snan_o,
    output logic [MAG_W-1:0]  mag_o
);

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones = &word_i[WORD_W-2:FRAC_W];
        frac_nz  = |word_i[FRAC_W-1:0];
        sign_o   = word_i[WORD_W-1];
        mag_o    = word_i[MAG_W-1:0];
        zero_o   = (word_i[MAG_W-1:0] == '0);
        nan_o    = exp_ones && frac_nz;
        // signalling when the top fraction bit is clear
        snan_o   = exp_ones && frac_nz && !word_i[FRAC_W-1];
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  logic             a_sign_i,
    input  logic             a_zero_i,
    input  logic             a_nan_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             b_sign_i,
    input  logic             b_zero_i,
    input  logic             b_nan_i,
    input  logic [MAG_W-1:0] b_mag_i,
    output rel_e             rel_o
);

    logic mag_eq;
    logic mag_gt;

    always_comb begin
        mag_eq = (a_mag_i == b_mag_i);
        mag_gt = (a_mag_i > b_mag_i);
        if (a_nan_i || b_nan_i) begin
            rel_o = REL_UN;
        end else if (a_zero_i && b_zero_i) begin
            rel_o = REL_EQ;
        end else if (a_sign_i != b_sign_i) begin
            rel_o = a_sign_i ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel_o = REL_EQ;
        end else begin
            // negative operands reverse the magnitude order
            rel_o = (mag_gt ^ a_sign_i) ? REL_GT : REL_LT;
        end
    end

endmodule

// File: rtl/fcmp_encode.sv
module fcmp_encode
    import fcmp_pkg::*;
(
    input  rel_e              rel_i,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        unique case (rel_i)
            REL_GT:  code_o = 3'b000;
            REL_LT:  code_o = 3'b001;
            REL_EQ:  code_o = 3'b100;
            default: code_o = 3'b111;
        endcase
    end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int MAX_POP = 2,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = EXP_W + FRAC_W,
    localparam int N_OPS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] op_a_i,
    input  logic [WORD_W-1:0] op_b_i,
    input  logic              quiet_i,
    input  logic              zero_i,
    input  logic              cpu_flags_i,
    input  logic [POP_W-1:0]  pops_i,
    output logic              done_o,
    output logic [CODE_W-1:0] cc_o,
    output logic [CODE_W-1:0] cpu_o,
    output logic              invalid_o,
    output logic [POP_W-1:0]  pop_o
);

    logic [WORD_W-1:0] op_word [N_OPS];
    logic [N_OPS-1:0]  op_sign;
    logic [N_OPS-1:0]  op_zero;
    logic [N_OPS-1:0]  op_nan;
    logic [N_OPS-1:0]  op_snan;
    logic [MAG_W-1:0]  op_mag [N_OPS];

    rel_e              rel;
    logic [CODE_W-1:0] code;
    logic [POP_W-1:0]  pops_lim;

    fcmp_state_t state_d;
    fcmp_state_t state_q;

    always_comb begin
        op_word[0] = op_a_i;
        op_word[1] = zero_i ? '0 : op_b_i;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fcmp_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) i_cls (
            .word_i (op_word[g]),
            .sign_o (op_sign[g]),
            .zero_o (op_zero[g]),
            .nan_o  (op_nan[g]),
            .snan_o (op_snan[g]),
            .mag_o  (op_mag[g])
        );
    end

    fcmp_order #(
        .MAG_W (MAG_W)
    ) i_order (
        .a_sign_i (op_sign[0]),
        .a_zero_i (op_zero[0]),
        .a_nan_i  (op_nan[0]),
        .a_mag_i  (op_mag[0]),
        .b_sign_i (op_sign[1]),
        .b_zero_i (op_zero[1]),
        .b_nan_i  (op_nan[1]),
        .b_mag_i  (op_mag[1]),
        .rel_o    (rel)
    );

    fcmp_encode i_encode (
        .rel_i  (rel),
        .code_o (code)
    );

    always_comb begin
        pops_lim = (int'(pops_i) > MAX_POP) ? POP_W'(MAX_POP) : pops_i;
    end

    always_comb begin
        state_d      = state_q;
        state_d.done = valid_i;
        state_d.inv  = 1'b0;
        state_d.pops = '0;
        if (valid_i) begin
            state_d.inv  = (|op_snan) || (!quiet_i && (|op_nan));
            state_d.pops = pops_lim;
            if (cpu_flags_i) begin
                state_d.cpu = code;
            end else begin
                state_d.cc = code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign done_o    = state_q.done;
    assign cc_o      = state_q.cc;
    assign cpu_o     = state_q.cpu;
    assign invalid_o = state_q.inv;
    assign pop_o     = state_q.pops;

endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_i,
    input logic       cpu_flags_i,
    input logic       done_o,
    input logic [2:0] cc_o,
    input logic [2:0] cpu_o,
    input logic       invalid_o,
    input logic [1:0] pop_o
);

    // R1
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    // R1
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);

    // R8
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || cpu_flags_i) |=> $stable(cc_o));

    // R8
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || !cpu_flags_i) |=> $stable(cpu_o));

    // R2
    cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_o == 3'b000) || (cc_o == 3'b001) || (cc_o == 3'b100) || (cc_o == 3'b111));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!invalid_o && (pop_o == 2'd0)));

    // R9
    pop_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pop_o != 2'd3));

    // R6
    invalid_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !cpu_flags_i) |=> (!invalid_o || (cc_o == 3'b111)));

endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk i_fcmp_flag_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .cpu_flags_i (cpu_flags_i),
    .done_o      (done_o),
    .cc_o        (cc_o),
    .cpu_o       (cpu_o),
    .invalid_o   (invalid_o),
    .pop_o       (pop_o)
);

// File: tb/test_fcmp_flag_unit.sv
module test_fcmp_flag_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    localparam logic [31:0] P1   = 32'h3F800000;
    localparam logic [31:0] P2   = 32'h40000000;
    localparam logic [31:0] N1   = 32'hBF800000;
    localparam logic [31:0] N2   = 32'hC0000000;
    localparam logic [31:0] PZ   = 32'h00000000;
    localparam logic [31:0] NZ   = 32'h80000000;
    localparam logic [31:0] PINF = 32'h7F800000;
    localparam logic [31:0] NINF = 32'hFF800000;
    localparam logic [31:0] PMAX = 32'h7F7FFFFF;
    localparam logic [31:0] QN   = 32'h7FC00000;
    localparam logic [31:0] SN   = 32'h7F800001;
    localparam logic [31:0] DEN  = 32'h00000001;

    // {a, b, quiet, zero, cpu, pops, code, inv, pop}
    localparam logic [74:0] VEC [NVEC] = '{
        {P2,   P1,   1'b0, 1'b0, 1'b0, 2'd0, 3'b000, 1'b0, 2'd0},
        {P1,   P2,   1'b0, 1'b0, 1'b0, 2'd0, 3'b001, 1'b0, 2'd0},
        {P1,   P1,   1'b0, 1'b0, 1'b0, 2'd0, 3'b100, 1'b0, 2'd0},
        {N2,   N1,   1'b0, 1'b0, 1'b0, 2'd0, 3'b001, 1'b0, 2'd0},
        {N1,   N2,   1'b0, 1'b0, 1'b0, 2'd0, 3'b000, 1'b0, 2'd0},
        {N1,   P1,   1'b0, 1'b0, 1'b0, 2'd0, 3'b001, 1'b0, 2'd0},
        {PZ,   NZ,   1'b0, 1'b0, 1'b0, 2'd0, 3'b100, 1'b0, 2'd0},
        {NINF, N2,   1'b0, 1'b0, 1'b0, 2'd0, 3'b001, 1'b0, 2'd0},
        {PINF, PMAX, 1'b0, 1'b0, 1'b0, 2'd0, 3'b000, 1'b0, 2'd0},
        {QN,   P1,   1'b1, 1'b0, 1'b0, 2'd0, 3'b111, 1'b0, 2'd0},
        {P1,   QN,   1'b0, 1'b0, 1'b0, 2'd0, 3'b111, 1'b1, 2'd0},
        {SN,   P1,   1'b1, 1'b0, 1'b0, 2'd0, 3'b111, 1'b1, 2'd0},
        {N1,   P2,   1'b0, 1'b1, 1'b0, 2'd0, 3'b001, 1'b0, 2'd0},
        {DEN,  QN,   1'b0, 1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 2'd0},
        {NZ,   N2,   1'b0, 1'b1, 1'b0, 2'd0, 3'b100, 1'b0, 2'd0},
        {P1,   P2,   1'b0, 1'b0, 1'b1, 2'd0, 3'b001, 1'b0, 2'd0},
        {QN,   P1,   1'b0, 1'b0, 1'b1, 2'd3, 3'b111, 1'b1, 2'd2},
        {P2,   P1,   1'b0, 1'b0, 1'b0, 2'd1, 3'b000, 1'b0, 2'd1},
        {P1,   P1,   1'b0, 1'b0, 1'b1, 2'd2, 3'b100, 1'b0, 2'd2}
    };

    localparam string VTAG [NVEC] = '{
        "R2", "R2", "R2", "R3", "R3", "R3", "R4", "R3", "R3", "R5/R6",
        "R5/R6", "R6", "R7", "R7", "R7", "R8", "R9", "R9", "R8"
    };

    logic       clk;
    logic       rst_n;
    logic       valid_i;
    logic [31:0] op_a_i;
    logic [31:0] op_b_i;
    logic       quiet_i;
    logic       zero_i;
    logic       cpu_flags_i;
    logic [1:0] pops_i;
    logic       done_o;
    logic [2:0] cc_o;
    logic [2:0] cpu_o;
    logic       invalid_o;
    logic [1:0] pop_o;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_cc = 3'b000;
    logic [2:0] exp_cpu = 3'b000;

    fcmp_flag_unit i_fcmp_flag_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .op_a_i      (op_a_i),
        .op_b_i      (op_b_i),
        .quiet_i     (quiet_i),
        .zero_i      (zero_i),
        .cpu_flags_i (cpu_flags_i),
        .pops_i      (pops_i),
        .done_o      (done_o),
        .cc_o        (cc_o),
        .cpu_o       (cpu_o),
        .invalid_o   (invalid_o),
        .pop_o       (pop_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag, input logic done_e,
                                 input logic inv_e, input logic [1:0] pop_e);
        check(done_o == done_e, tag, "done_o", 32'(done_o), 32'(done_e));
        check(cc_o == exp_cc, tag, "cc_o", 32'(cc_o), 32'(exp_cc));
        check(cpu_o == exp_cpu, tag, "cpu_o", 32'(cpu_o), 32'(exp_cpu));
        check(invalid_o == inv_e, tag, "invalid_o", 32'(invalid_o), 32'(inv_e));
        check(pop_o == pop_e, tag, "pop_o", 32'(pop_o), 32'(pop_e));
    endtask

    task automatic strobe(input logic [74:0] v, input string tag);
        op_a_i      = v[74:43];
        op_b_i      = v[42:11];
        quiet_i     = v[10];
        zero_i      = v[9];
        cpu_flags_i = v[8];
        pops_i      = v[7:6];
        valid_i     = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        if (v[8]) exp_cpu = v[5:3];
        else      exp_cc  = v[5:3];
        check_outputs(tag, 1'b1, v[2], v[1:0]);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        valid_i = 1'b0;
        op_a_i = '0;
        op_b_i = '0;
        quiet_i = 1'b0;
        zero_i = 1'b0;
        cpu_flags_i = 1'b0;
        pops_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_outputs("R1", 1'b0, 1'b0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1", 1'b0, 1'b0, 2'd0);

        // vector table, strobes back to back (R1 each result a cycle later)
        for (int i = 0; i < NVEC; i++) begin
            strobe(VEC[i], VTAG[i]);
        end

        // R10: idle cycle after a strobe that raised invalid and popped
        strobe({QN, P1, 1'b0, 1'b0, 1'b0, 2'd2, 3'b111, 1'b1, 2'd2}, "R6");
        @(negedge clk);
        check_outputs("R10", 1'b0, 1'b0, 2'd0);

        // R8: inputs churn with no strobe, both flag sets hold
        op_a_i = N2;
        op_b_i = P2;
        cpu_flags_i = 1'b1;
        pops_i = 2'd3;
        repeat (3) @(negedge clk);
        check_outputs("R8", 1'b0, 1'b0, 2'd0);

        // R7: zero mode with signalling NaN on B stays silent
        strobe({P2, SN, 1'b0, 1'b1, 1'b1, 2'd0, 3'b000, 1'b0, 2'd0}, "R7");

        // R1: reset mid-run clears everything
        strobe({N1, P1, 1'b0, 1'b0, 1'b0, 2'd1, 3'b001, 1'b0, 2'd1}, "R3");
        rst_n = 1'b0;
        @(negedge clk);
        exp_cc = 3'b000;
        exp_cpu = 3'b000;
        check_outputs("R1", 1'b0, 1'b0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule